// File: doc/BRIEF.md
# Frame-Paced Byte Handshake Channel

This block carries a byte-wide message between two devices sharing a time-division frame. Each frame offers one data byte and two flow-control bits, both active low. The first bit says "a valid byte is on the line" and the second says "byte accepted". The block holds both ends of the link. The sending half repeats its byte every frame until the far side accepts it. The receiving half latches the bytes it sees and returns acceptances once the local processor has consumed each byte.

Two kinds of edge mark the message. The first byte, or the first acceptance, is marked by the bit turning active. Each later byte, or later acceptance, is marked by the bit going idle for exactly one frame and then active again. Two idle frames in a row end the message when they come on the valid bit. On the accept bit they cancel it. The processor sees two registers, one byte to send and one byte received, plus two enables that can force either outgoing bit idle. It also sees four sticky event flags and a busy indication. Nothing in the handshake times out.

Top module: `mhs_channel`

## Requirements
- R1: A frame strobe seen while `mx_en` is low leaves `tx_mx` at 1 after that strobe. A frame strobe seen while `mr_en` is low leaves `tx_mr` at 1.
- R2: `tx_byte`, `tx_mx` and `tx_mr` change only in the clock cycle after a frame strobe.
- R3: Suppose `mx_en` is high and a byte has been written while the sender is idle. The next strobe drives `tx_mx` to 0 and puts that byte on `tx_byte`. The same byte and `tx_mx`=0 are then repeated at every frame until an acceptance arrives.
- R4: A strobe where `rx_mx` is 0 and was 1 at the previous strobe stores `rx_byte` into `rd_data` and sets `irq_rcv`. This happens whatever `irq_en` and `mr_en` are.
- R5: The first acceptance drives `tx_mr` to 0. It is sent only at the first strobe after the stored byte has been read (`din_rd`) with `mr_en` high. `tx_mr` then stays 0.
- R6: A later byte is accepted with `tx_mr`=1 for exactly one frame and then 0. This starts at the first strobe after its read.
- R7: While the sender waits, a strobe where `rx_mr` is 0 and was 1 at the previous strobe counts as an acceptance and sets `irq_ack`. `tx_mx` stays 0.
- R8: A byte written after an acceptance is sent as one frame of `tx_mx`=1. The next frame brings `tx_mx`=0 with the new byte.
- R9: Once a byte has been received, `rx_mx`=1 at two consecutive strobes sets `irq_end`. A single idle frame does not.
- R10: Suppose at least one acceptance has been seen in the current transfer. Then `rx_mr`=1 at two consecutive strobes sets `irq_abort`, and `tx_mx` is forced to 1 until `mx_en` is cleared. Before any acceptance, idle accept frames never abort.
- R11: All four flags clear on `irq_rd`. A flag set in the same cycle wins over the clear. `irq_ack`, `irq_end` and `irq_abort` are set only while `irq_en` is high.
- R12: `active` is 1 while the sender is engaged or `tx_mr` is 0. It is 0 after a strobe taken with both enables low.
- R13: No step of the handshake has a time limit. The sender keeps repeating its unaccepted byte for any number of frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| frame_stb | input | 1 | one-cycle pulse per frame; samples frame inputs |
| rx_byte | input | DW | incoming frame byte |
| rx_mx | input | 1 | incoming valid bit, active low |
| rx_mr | input | 1 | incoming accept bit, active low |
| tx_byte | output | DW | outgoing frame byte |
| tx_mx | output | 1 | outgoing valid bit, active low |
| tx_mr | output | 1 | outgoing accept bit, active low |
| mx_en | input | 1 | enables the sending half; low forces `tx_mx` idle |
| mr_en | input | 1 | enables acceptances; low forces `tx_mr` idle |
| irq_en | input | 1 | gates the accept, end and abort flags |
| wr_en | input | 1 | writes `wr_data` as the next byte to send |
| wr_data | input | DW | byte to send |
| din_rd | input | 1 | processor has read `rd_data` |
| rd_data | output | DW | last received byte |
| irq_rd | input | 1 | clears all flags |
| irq_rcv | output | 1 | byte received |
| irq_ack | output | 1 | sent byte accepted |
| irq_end | output | 1 | end of received message |
| irq_abort | output | 1 | transfer cancelled by peer |
| active | output | 1 | transfer in progress |

## Verification
A wrong sender state would appear within one frame. It would show up either as a stray idle frame on `tx_mx` or as a missing repeat of the byte. A wrong previous-frame sample on either incoming bit would make an acceptance, end or abort flag appear one frame early or not at all. The receiver's read tracking shows directly on `tx_mr`. An acceptance that goes out before `din_rd`, or an idle gap that lasts zero or two frames, is visible at the first strobe after the read.

// File: rtl/mhs_pkg.sv
package mhs_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT,
    TX_DONE,
    TX_GAP,
    TX_HALT
  } tx_st_t;

  // bit moved from idle (1) to active (0) between two frames
  function automatic logic fn_went_active(input logic cur, input logic prev);
    return prev & ~cur;
  endfunction

  // bit idle in two consecutive frames
  function automatic logic fn_two_idle(input logic cur, input logic prev);
    return cur & prev;
  endfunction

endpackage

// File: rtl/mhs_tx.sv
module mhs_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          mx_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rx_mr,
  output logic          tx_mx,
  output logic [DW-1:0] tx_byte,
  output logic          ev_ack,
  output logic          ev_abt,
  output logic          busy
);
  import mhs_pkg::*;

  tx_st_t        st_q;
  logic [DW-1:0] data_q, byte_q;
  logic          pend_q, mx_q, mr_prev_q, eng_q;
  logic          ack_seen, idle2, consume;

  assign ack_seen = fn_went_active(rx_mr, mr_prev_q);
  assign idle2    = fn_two_idle(rx_mr, mr_prev_q);
  assign ev_ack   = stb && mx_en && (st_q == TX_WAIT) && ack_seen;
  assign ev_abt   = stb && mx_en && eng_q && idle2 &&
                    ((st_q == TX_WAIT) || (st_q == TX_DONE));
  assign consume  = stb && mx_en &&
                    (((st_q == TX_IDLE) && pend_q) || (st_q == TX_GAP));

  assign tx_mx   = mx_q;
  assign tx_byte = byte_q;
  assign busy    = (st_q != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en) data_q <= wr_data;
      pend_q <= wr_en | (pend_q & ~consume);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= TX_IDLE;
      byte_q    <= '0;
      mx_q      <= 1'b1;
      mr_prev_q <= 1'b1;
      eng_q     <= 1'b0;
    end else if (stb) begin
      mr_prev_q <= rx_mr;
      if (!mx_en) begin
        st_q  <= TX_IDLE;
        mx_q  <= 1'b1;
        eng_q <= 1'b0;
      end else begin
        unique case (st_q)
          TX_IDLE: begin
            eng_q <= 1'b0;
            if (pend_q) begin
              mx_q   <= 1'b0;
              byte_q <= data_q;
              st_q   <= TX_WAIT;
            end
          end
          TX_WAIT: begin
            if (ev_ack) begin
              st_q  <= TX_DONE;
              eng_q <= 1'b1;
            end else if (ev_abt) begin
              st_q <= TX_HALT;
              mx_q <= 1'b1;
            end
          end
          TX_DONE: begin
            if (ev_abt) begin
              st_q <= TX_HALT;
              mx_q <= 1'b1;
            end else if (pend_q) begin
              mx_q <= 1'b1;
              st_q <= TX_GAP;
            end
          end
          TX_GAP: begin
            mx_q   <= 1'b0;
            byte_q <= data_q;
            st_q   <= TX_WAIT;
          end
          TX_HALT: mx_q <= 1'b1;
          default: st_q <= TX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mhs_rx.sv
module mhs_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          mr_en,
  input  logic          rx_mx,
  input  logic [DW-1:0] rx_byte,
  input  logic          din_rd,
  output logic          tx_mr,
  output logic [DW-1:0] rd_data,
  output logic          ev_rcv,
  output logic          ev_end,
  output logic          busy
);
  import mhs_pkg::*;

  logic [DW-1:0] data_q;
  logic          mx_prev_q, unread_q, need_q, mr_q, live_q;
  logic          ack_done;

  assign ev_rcv   = stb && fn_went_active(rx_mx, mx_prev_q);
  assign ev_end   = stb && live_q && fn_two_idle(rx_mx, mx_prev_q);
  assign ack_done = stb && mr_en && need_q && !unread_q && mr_q;

  assign tx_mr   = mr_q;
  assign rd_data = data_q;
  assign busy    = ~mr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      mx_prev_q <= 1'b1;
      unread_q  <= 1'b0;
      need_q    <= 1'b0;
      mr_q      <= 1'b1;
      live_q    <= 1'b0;
    end else begin
      if (ev_rcv) begin
        data_q <= rx_byte;
        live_q <= 1'b1;
      end else if (ev_end) begin
        live_q <= 1'b0;
      end
      if (ev_rcv) unread_q <= 1'b1;
      else if (din_rd) unread_q <= 1'b0;
      need_q <= ev_rcv | (need_q & ~ack_done);
      if (stb) begin
        mx_prev_q <= rx_mx;
        if (!mr_en) mr_q <= 1'b1;
        else if (need_q && !unread_q) mr_q <= ~mr_q;
      end
    end
  end

endmodule

// File: rtl/mhs_channel.sv
module mhs_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_mx,
  input  logic          rx_mr,
  output logic [DW-1:0] tx_byte,
  output logic          tx_mx,
  output logic          tx_mr,
  input  logic          mx_en,
  input  logic          mr_en,
  input  logic          irq_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          din_rd,
  output logic [DW-1:0] rd_data,
  input  logic          irq_rd,
  output logic          irq_rcv,
  output logic          irq_ack,
  output logic          irq_end,
  output logic          irq_abort,
  output logic          active
);
  localparam int NFLAG = 4;

  logic ev_ack, ev_abt, ev_rcv, ev_end;
  logic tx_busy, rx_busy;
  logic [NFLAG-1:0] ev_vec, flag_q;

  mhs_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .mx_en(mx_en),
    .wr_en(wr_en), .wr_data(wr_data), .rx_mr(rx_mr),
    .tx_mx(tx_mx), .tx_byte(tx_byte), .ev_ack(ev_ack), .ev_abt(ev_abt),
    .busy(tx_busy)
  );

  mhs_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .mr_en(mr_en),
    .rx_mx(rx_mx), .rx_byte(rx_byte), .din_rd(din_rd),
    .tx_mr(tx_mr), .rd_data(rd_data), .ev_rcv(ev_rcv), .ev_end(ev_end),
    .busy(rx_busy)
  );

  // received flag is ungated; the rest follow irq_en
  assign ev_vec = {ev_abt & irq_en, ev_end & irq_en, ev_ack & irq_en, ev_rcv};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= ev_vec[g] | (flag_q[g] & ~irq_rd);
    end
  end

  assign irq_rcv   = flag_q[0];
  assign irq_ack   = flag_q[1];
  assign irq_end   = flag_q[2];
  assign irq_abort = flag_q[3];
  assign active    = tx_busy | rx_busy;

endmodule

// File: rtl/mhs_channel_chk.sv
module mhs_channel_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_stb,
  input logic          mx_en,
  input logic          mr_en,
  input logic          tx_mx,
  input logic          tx_mr,
  input logic [DW-1:0] tx_byte,
  input logic          active,
  input logic          irq_rcv,
  input logic          ev_ack,
  input logic          ev_abt
);

  a_r1_mx_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !mx_en) |=> tx_mx);

  a_r1_mr_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !mr_en) |=> tx_mr);

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(tx_mx) && $stable(tx_mr) && $stable(tx_byte)));

  a_r10_ack_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ack, ev_abt}));

  a_r11_rcv_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rcv) |-> $past(frame_stb));

  a_r12_active_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !mx_en && !mr_en) |=> !active);

endmodule

bind mhs_channel mhs_channel_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_en(mx_en),
  .mr_en(mr_en), .tx_mx(tx_mx), .tx_mr(tx_mr), .tx_byte(tx_byte),
  .active(active), .irq_rcv(irq_rcv), .ev_ack(ev_ack), .ev_abt(ev_abt)
);

// File: tb/mhs_channel_tb_top.sv
module mhs_channel_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic rx_mx = 1'b1, rx_mr = 1'b1;
  logic [DW-1:0] tx_byte;
  logic tx_mx, tx_mr;
  logic mx_en = 1'b0, mr_en = 1'b0, irq_en = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic din_rd = 1'b0;
  logic [DW-1:0] rd_data;
  logic irq_rd = 1'b0;
  logic irq_rcv, irq_ack, irq_end, irq_abort, active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mhs_channel #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_byte(rx_byte),
    .rx_mx(rx_mx), .rx_mr(rx_mr), .tx_byte(tx_byte), .tx_mx(tx_mx),
    .tx_mr(tx_mr), .mx_en(mx_en), .mr_en(mr_en), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .din_rd(din_rd), .rd_data(rd_data),
    .irq_rd(irq_rd), .irq_rcv(irq_rcv), .irq_ack(irq_ack),
    .irq_end(irq_end), .irq_abort(irq_abort), .active(active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one frame: inputs set at a falling edge, strobe for one cycle,
  // outputs sampled at the falling edge after the capturing rising edge
  task automatic frm(input logic [DW-1:0] b, input logic mx, input logic mr);
    @(negedge clk);
    rx_byte = b; rx_mx = mx; rx_mr = mr; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic put(input logic [DW-1:0] b);
    @(negedge clk); wr_data = b; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_din();
    @(negedge clk); din_rd = 1'b1;
    @(negedge clk); din_rd = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); irq_rd = 1'b1;
    @(negedge clk); irq_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset tx_mx", tx_mx, 1);
    chk("reset tx_mr", tx_mr, 1);
    chk("reset active", active, 0);
    chk("reset flags", {irq_rcv, irq_ack, irq_end, irq_abort}, 0);

    // ---------- sending half ----------
    put(8'h5A);
    frm(0, 1, 1);
    chk("R1 mx idle when disabled", tx_mx, 1);
    mx_en = 1'b1;
    frm(0, 1, 1);
    chk("R3 first byte mx", tx_mx, 0);
    chk("R3 first byte data", tx_byte, 8'h5A);
    chk("R12 active while sending", active, 1);
    for (int k = 0; k < 20; k++) frm(0, 1, 1);
    chk("R13 still repeating mx", tx_mx, 0);
    chk("R13 still repeating data", tx_byte, 8'h5A);
    chk("R10 no abort before first ack", irq_abort, 0);
    // R2: no strobe, inputs and write change, outputs must hold
    @(negedge clk); rx_mr = 1'b0;
    put(8'hEE);
    repeat (4) @(negedge clk);
    chk("R2 mx held without strobe", tx_mx, 0);
    chk("R2 byte held without strobe", tx_byte, 8'h5A);
    chk("R2 no ack without strobe", irq_ack, 0);
    frm(0, 1, 0);
    chk("R7 ack flag", irq_ack, 1);
    chk("R7 mx stays active", tx_mx, 0);
    clr();
    chk("R11 ack cleared on read", irq_ack, 0);
    // pending 8'hEE goes out via the gap
    frm(0, 1, 0);
    chk("R8 gap frame", tx_mx, 1);
    frm(0, 1, 0);
    chk("R8 second byte", tx_byte, 8'hEE);
    frm(0, 1, 1);
    frm(0, 1, 0);
    chk("R7 second ack", irq_ack, 1);
    clr();

    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] b;
      b = DW'(i * 37 + 3);
      irq_en = (i != 7);
      put(b);
      frm(0, 1, 0);
      chk("R8 gap frame", tx_mx, 1);
      frm(0, 1, 0);
      chk("R8 mx back active", tx_mx, 0);
      chk("R8 new byte", tx_byte, b);
      frm(0, 1, 1);
      chk("R7 no ack during peer gap", irq_ack, 0);
      chk("R10 single idle no abort", irq_abort, 0);
      frm(0, 1, 0);
      chk("R11 ack gated by irq_en", irq_ack, (i != 7));
      clr();
    end
    irq_en = 1'b1;

    frm(0, 1, 1);
    chk("R10 one idle accept frame", irq_abort, 0);
    chk("R10 mx active after one idle", tx_mx, 0);
    frm(0, 1, 1);
    chk("R10 abort flag", irq_abort, 1);
    chk("R10 mx forced idle", tx_mx, 1);
    frm(0, 1, 0);
    chk("R10 mx stays idle", tx_mx, 1);
    chk("R12 active during halt", active, 1);
    clr();
    mx_en = 1'b0;
    frm(0, 1, 1);
    chk("R12 active drops", active, 0);

    // ---------- receiving half ----------
    irq_en = 1'b0;
    frm(0, 1, 1);
    frm(8'hC3, 0, 1);
    chk("R4 rcv flag ungated", irq_rcv, 1);
    chk("R4 stored byte", rd_data, 8'hC3);
    chk("R1 mr idle when disabled", tx_mr, 1);
    clr();
    frm(8'h11, 0, 1);
    chk("R4 no rcv without edge", irq_rcv, 0);
    chk("R4 byte kept without edge", rd_data, 8'hC3);
    mr_en = 1'b1;
    frm(0, 0, 1);
    chk("R5 no ack before read", tx_mr, 1);
    rd_din();
    frm(0, 0, 1);
    chk("R5 first ack", tx_mr, 0);
    chk("R12 active while accepting", active, 1);
    frm(0, 0, 1);
    chk("R5 ack held", tx_mr, 0);
    irq_en = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] b;
      b = DW'(i * 53 + 9);
      frm(0, 1, 1);
      chk("R9 single idle no end", irq_end, 0);
      frm(b, 0, 1);
      chk("R4 later byte flag", irq_rcv, 1);
      chk("R4 later byte data", rd_data, b);
      chk("R6 mr held before read", tx_mr, 0);
      clr();
      rd_din();
      frm(0, 0, 1);
      chk("R6 accept gap", tx_mr, 1);
      frm(0, 0, 1);
      chk("R6 accept active again", tx_mr, 0);
    end

    frm(0, 1, 1);
    chk("R9 one idle frame", irq_end, 0);
    frm(0, 1, 1);
    chk("R9 end flag", irq_end, 1);
    mr_en = 1'b0;
    frm(0, 1, 1);
    chk("R1 mr idle after disable", tx_mr, 1);
    chk("R12 active low at end", active, 0);
    clr();
    chk("R11 all flags cleared", {irq_rcv, irq_ack, irq_end, irq_abort}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule